// File: doc/BRIEF.md
# Write-Once Memory Timing Clock Divider

This block derives the slow timing strobe that a nonvolatile memory controller needs from the bus clock. Software programs one 8-bit control register through a simple select/write/address bus. The register holds a divisor field and a prescale select. The control fields accept exactly one write after reset, and a read-only flag in the top bit reports that this write has happened. Until the flag is set, the divider stays idle and the program/erase enable output stays low. This keeps the memory from being erased or programmed with an unknown timebase.

Once loaded, the divider produces a single-bus-cycle enable pulse. The pulse comes every (DIV+1) bus cycles, or every 8×(DIV+1) bus cycles when the prescale select is 1. Software chooses the values so that the pulse rate falls between 150 kHz and 200 kHz. One pulse period (about 5 µs to 6.7 µs) is then the basic program/erase timing unit.

Top module: `nvm_tick_divider`

## Requirements
- R1: After reset the register reads 0x00, and `tick_o` and `pe_enable_o` are 0.
- R2: The first write to the register after reset sets the loaded flag (read bit 7) to 1, whatever the written data, including 0x00.
- R3: The first write stores write-data bits 6:0 (bit 6 = prescale select, bits 5:0 = divisor DIV). Every later write leaves them unchanged.
- R4: Write-data bit 7 has no effect on the value read back. A read returns the live loaded flag in bit 7 and the stored fields in bits 6:0.
- R5: With prescale select 0, `tick_o` is high in the cycle right after the loading write's clock edge when DIV=0. In general it is high exactly in every (DIV+1)-th cycle, counting that cycle as the first.
- R6: With prescale select 1, `tick_o` is high exactly in every 8×(DIV+1)-th cycle after the loading write, counting the same way as in R5.
- R7: While the loaded flag is 0, `tick_o` stays 0.
- R8: `pe_enable_o` equals the loaded flag in every cycle.
- R9: A write with `bus_sel` low or with an address other than the register address changes nothing. A read under either condition returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Block select for reads and writes |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W (3) | Register address; the register sits at REG_ADDR (0) |
| bus_wdata | input | DIV_W+2 (8) | Write data |
| bus_rdata | output | DIV_W+2 (8) | Combinational read data |
| tick_o | output | 1 | One-cycle timing enable pulse |
| pe_enable_o | output | 1 | Program/erase permitted |

## Verification
Because the fields lock after the first write, no divisor or prescale setting can be reached from another setting without a fresh reset. The stimulus therefore resets the block once for each of the 128 combinations of DIV and prescale select, loads that setting, and compares every cycle against a counting model. A second write of the complemented value is issued one period into each run. This shows that the lock holds while the divider is mid-count and that the pulse phase does not shift. Before each load, a write to a wrong address shows that the flag stays clear.

// File: rtl/nvm_tick_pkg.sv
package nvm_tick_pkg;

   typedef enum logic {
      PRE_BYPASS = 1'b0,
      PRE_DIVIDE = 1'b1
   } pre_mode_e;

endpackage

// File: rtl/nvm_tick_cfg_reg.sv
module nvm_tick_cfg_reg #(
   parameter int DIV_W    = 6,
   parameter int ADDR_W   = 3,
   parameter int REG_ADDR = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DIV_W+1:0]    wdata,
   output logic [DIV_W+1:0]    rdata,
   output logic                loaded_o,
   output nvm_tick_pkg::pre_mode_e pre_o,
   output logic [DIV_W-1:0]    div_o
);
   import nvm_tick_pkg::*;

   localparam int REG_W = DIV_W + 2;

   if (REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("REG_ADDR does not fit in ADDR_W bits");
   end

   logic       hit;
   logic       wr_ok;
   logic       loaded_q;
   pre_mode_e  pre_q;
   logic [DIV_W-1:0] div_q;
   logic       unused_wflag;

   assign hit          = sel && (addr == ADDR_W'(REG_ADDR));
   assign wr_ok        = hit && we && !loaded_q;
   assign unused_wflag = wdata[REG_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loaded_q <= 1'b0;
         pre_q    <= PRE_BYPASS;
         div_q    <= '0;
      end else if (wr_ok) begin
         loaded_q <= 1'b1;
         pre_q    <= pre_mode_e'(wdata[DIV_W]);
         div_q    <= wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit) rdata = {loaded_q, pre_q, div_q};
   end

   assign loaded_o = loaded_q;
   assign pre_o    = pre_q;
   assign div_o    = div_q;

   a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q |=> loaded_q);

   a_r3_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q |=> ($stable(div_q) && $stable(pre_q)));

endmodule

// File: rtl/nvm_tick_prescale.sv
module nvm_tick_prescale #(
   parameter int RATIO = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  nvm_tick_pkg::pre_mode_e mode,
   output logic                    tick_o
);
   import nvm_tick_pkg::*;

   localparam int CW   = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam bit POW2 = (RATIO > 1) && ((RATIO & (RATIO - 1)) == 0);

   if (RATIO < 2) begin : g_bad_ratio
      $error("RATIO must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end = (cnt_q == CW'(RATIO - 1));

   if (POW2) begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n || !run || mode == PRE_BYPASS) cnt_q <= '0;
         else                                      cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n || !run || mode == PRE_BYPASS) cnt_q <= '0;
         else if (at_end)                          cnt_q <= '0;
         else                                      cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = run && ((mode == PRE_BYPASS) || at_end);

   a_r6_prescale_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && mode == PRE_DIVIDE) |=> !tick_o);

endmodule

// File: rtl/nvm_tick_counter.sv
module nvm_tick_counter #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [DIV_W-1:0] limit,
   output logic             tick_o
);
   if (DIV_W < 1) begin : g_bad_width
      $error("DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (step)      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
   end

   assign tick_o = run && step && wrap;

   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= limit));

endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider #(
   parameter int DIV_W     = 6,
   parameter int ADDR_W    = 3,
   parameter int REG_ADDR  = 0,
   parameter int PRE_RATIO = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DIV_W+1:0]    bus_wdata,
   output logic [DIV_W+1:0]    bus_rdata,
   output logic                tick_o,
   output logic                pe_enable_o
);
   import nvm_tick_pkg::*;

   logic             loaded;
   pre_mode_e        pre_mode;
   logic [DIV_W-1:0] div_val;
   logic             pre_tick;

   nvm_tick_cfg_reg #(
      .DIV_W   (DIV_W),
      .ADDR_W  (ADDR_W),
      .REG_ADDR(REG_ADDR)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (bus_sel),
      .we      (bus_we),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (bus_rdata),
      .loaded_o(loaded),
      .pre_o   (pre_mode),
      .div_o   (div_val)
   );

   nvm_tick_prescale #(
      .RATIO(PRE_RATIO)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (loaded),
      .mode  (pre_mode),
      .tick_o(pre_tick)
   );

   nvm_tick_counter #(
      .DIV_W(DIV_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (loaded),
      .step  (pre_tick),
      .limit (div_val),
      .tick_o(tick_o)
   );

   assign pe_enable_o = loaded;

   a_r7_idle_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      !pe_enable_o |-> !tick_o);

   a_r8_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
      pe_enable_o |=> pe_enable_o);

endmodule

// File: tb/nvm_tick_divider_test.sv
module nvm_tick_divider_test;
   localparam int DIV_W  = 6;
   localparam int ADDR_W = 3;
   localparam int REG_W  = DIV_W + 2;
   localparam int NDIV   = 1 << DIV_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_we = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [REG_W-1:0]  bus_wdata = '0;
   logic [REG_W-1:0]  bus_rdata;
   logic              tick_o;
   logic              pe_enable_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   nvm_tick_divider uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .tick_o     (tick_o),
      .pe_enable_o(pe_enable_o)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic bus_idle();
      bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic do_write(input int a, input int d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = REG_W'(d);
      @(negedge clk);
      bus_idle();
   endtask

   task automatic read_check(input string req, input int a, input logic s, input int exp);
      bus_sel = s; bus_we = 1'b0; bus_addr = ADDR_W'(a);
      #1;
      check(req, int'(bus_rdata), exp);
      bus_idle();
   endtask

   task automatic run_case(input int pre, input int dv);
      int period = (pre != 0) ? 8 * (dv + 1) : dv + 1;
      int first  = ((dv & 1) << 7) | (pre << 6) | dv;
      int second = ((~first) & 8'h7F);
      string rq  = (pre != 0) ? "R6" : "R5";
      bus_idle();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1: reset state
      read_check("R1", 0, 1'b1, 0);
      check("R1", int'(tick_o), 0);
      check("R1", int'(pe_enable_o), 0);
      rst_n = 1'b1;
      // R9: stray writes and reads
      do_write(1, 8'h7F);
      @(negedge clk);
      read_check("R9", 0, 1'b1, 0);
      read_check("R9", 0, 1'b0, 0);
      check("R7", int'(tick_o), 0);
      check("R8", int'(pe_enable_o), 0);
      // load; R2/R4 via readback
      do_write(0, first);
      read_check("R4", 0, 1'b1, 8'h80 | (first & 8'h7F));
      read_check("R9", 2, 1'b1, 0);
      // cycle-by-cycle compare; a second write lands one period in
      for (int k = 0; k < 3 * period; k++) begin
         if (k == period) begin
            bus_sel = 1'b1; bus_we = 1'b1; bus_addr = '0; bus_wdata = REG_W'(second);
         end else if (k == period + 1) begin
            bus_idle();
         end
         check(rq, int'(tick_o), (((k + 1) % period) == 0) ? 1 : 0);
         check("R8", int'(pe_enable_o), 1);
         @(negedge clk);
      end
      // R3: fields unchanged by second write; R2 flag still set
      read_check("R3", 0, 1'b1, 8'h80 | (first & 8'h7F));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R2: zero data still sets the flag
      run_case(0, 0);
      for (int p = 0; p < 2; p++) begin
         for (int d = 0; d < NDIV; d++) begin
            run_case(p, d);
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule